// File: doc/BRIEF.md
# ALU Control Decoder

This block turns a 3-bit sequencing command and the 4-bit data-processing opcode field into the control word for a 32-bit ALU. The control word holds the function select, the carry presented to bit 0, the condition-flag update enable, an arithmetic/logical indicator and a result-write indicator that goes low for comparisons. When the command is all ones, the opcode picks the operation, one entry per data-processing instruction. The other seven command values are internal ALU uses that the sequencer issues on its own. These include address arithmetic with a carry of one, and reverse subtraction that borrows one.

The carry from the status register passes through a one-cycle delay register. The carry-in selector then passes this delayed carry on, or replaces it with a constant 0 or 1. The block also drives the operand-1 latch enable. That enable follows the request from the instruction decoder, and it is also asserted in the cycle after a cycle in which all three command bits were low. In a single-clock design the latch strobe is taken at the rising edge that ends the cycle. This stands in for the trailing edge of the first clock phase.

Top module: `alu_ctrl_decoder`

## Requirements
- R1: After reset, the carry delay register and the zero-command history are both cleared. Until the first clock after reset, alu_cin is 0 when the pass-carry mode is selected, and op1_latch_en equals op1_load_req.
- R2: In pass-carry mode, alu_cin equals the value status_carry had one clock earlier. Pass-carry mode covers opcodes 5 (add with carry), 6 (subtract with carry) and 7 (reverse subtract with carry) under command 3'b111, and also command 3'b110.
- R3: Under command 3'b111, alu_cin is forced to 1 for opcodes 2 (subtract), 3 (reverse subtract) and 10 (compare). It is forced to 0 for opcodes 4 (add) and 11 (compare negative), and for all logical opcodes.
- R4: Under command 3'b111, alu_fn is taken from the opcode using these codes: 0 AND, 1 EOR, 2 SUB (op1-op2), 3 RSB (op2-op1), 4 ADD, 5 ORR, 6 MOV, 7 BIC, 8 MVN. The mapping is opcode 0→AND, 1→EOR, 2→SUB, 3→RSB, 4→ADD, 5→ADD, 6→SUB, 7→RSB, 8→AND, 9→EOR, 10→SUB, 11→ADD, 12→ORR, 13→MOV, 14→BIC, 15→MVN.
- R5: result_wr is 0 for opcodes 8 to 11 (the comparisons) under command 3'b111. It is 1 for every other opcode and for every internal command.
- R6: flag_upd is 1 for every opcode under command 3'b111, and 0 for every other command.
- R7: arith_op is 1 for opcodes 2 to 7, 10 and 11 under command 3'b111, and 0 for the logical opcodes 0, 1, 8, 9 and 12 to 15.
- R8: Internal commands decode as follows (function, carry, arith_op), and the opcode has no effect on them: 000 MOV/0/0, 001 ADD/0/1, 010 ADD/1/1 (op1+op2+1), 011 RSB/0/1 (op2-op1-1), 100 SUB/1/1, 101 RSB/1/1, 110 ADD/pass/1.
- R9: op1_latch_en is 1 when op1_load_req is 1, and also in any cycle that directly follows a clock edge at which seq_cmd was 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_cmd | input | 3 | Sequencing command; 3'b111 selects opcode decode |
| opcode | input | 4 | Data-processing opcode field |
| status_carry | input | 1 | Carry flag from the status register |
| op1_load_req | input | 1 | Operand-1 latch request from the instruction decoder |
| alu_fn | output | 4 | ALU function select (codes in R4) |
| alu_cin | output | 1 | Carry into ALU bit 0 |
| flag_upd | output | 1 | Condition-flag update enable |
| arith_op | output | 1 | High for arithmetic operations |
| result_wr | output | 1 | Low for comparison opcodes |
| op1_latch_en | output | 1 | Operand-1 latch enable |

## Verification
Two functions can land in the same cycle. One is the delayed carry passing into an add-with-carry decode. The other is the operand-1 enable raised by a zero command in the cycle before. The bench sets this up by issuing command 3'b000 with status_carry at some value. In the next cycle it issues command 3'b111 with opcode 5, with status_carry now at the opposite value and op1_load_req low. The behavioural model predicts the old carry on alu_cin and a high latch enable, and it compares both outputs on every clock of the sweep.

// File: rtl/alu_ctrl_pkg.sv
// Shared widths, function codes and control-word type of the ALU control decoder.
// Assumes a 4-bit opcode field and a 3-bit sequencing command.
package alu_ctrl_pkg;
    parameter int CMD_W = 3;
    parameter int OPC_W = 4;
    parameter int FN_W  = 4;

    localparam logic [CMD_W-1:0] CMD_ARCH = {CMD_W{1'b1}};
    localparam logic [CMD_W-1:0] CMD_ZERO = {CMD_W{1'b0}};

    typedef enum logic [FN_W-1:0] {
        FN_AND = 4'd0,
        FN_EOR = 4'd1,
        FN_SUB = 4'd2,
        FN_RSB = 4'd3,
        FN_ADD = 4'd4,
        FN_ORR = 4'd5,
        FN_MOV = 4'd6,
        FN_BIC = 4'd7,
        FN_MVN = 4'd8
    } alu_fn_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_PASS = 2'd2
    } cin_sel_e;

    typedef struct packed {
        alu_fn_e  fn;
        cin_sel_e cin;
        logic     flag_upd;
        logic     arith;
        logic     result_wr;
    } ctl_word_t;
endpackage

// File: rtl/alu_ctrl_table.sv
// Combinational decode table: command plus opcode to ALU control word.
// Assumes command all-ones selects opcode decode; other values are internal uses.
module alu_ctrl_table
    import alu_ctrl_pkg::*;
(
    input  logic [CMD_W-1:0] seq_cmd,
    input  logic [OPC_W-1:0] opcode,
    output ctl_word_t        word
);
    ctl_word_t arch_word;
    ctl_word_t int_word;

    // Opcode-driven entry, one per data-processing operation.
    always_comb begin
        arch_word.flag_upd  = 1'b1;
        arch_word.result_wr = 1'b1;
        arch_word.arith     = 1'b1;
        arch_word.cin       = CIN_ZERO;
        arch_word.fn        = FN_AND;
        unique case (opcode)
            4'd0:  begin arch_word.fn = FN_AND; arch_word.arith = 1'b0; end
            4'd1:  begin arch_word.fn = FN_EOR; arch_word.arith = 1'b0; end
            4'd2:  begin arch_word.fn = FN_SUB; arch_word.cin = CIN_ONE;  end
            4'd3:  begin arch_word.fn = FN_RSB; arch_word.cin = CIN_ONE;  end
            4'd4:  begin arch_word.fn = FN_ADD; arch_word.cin = CIN_ZERO; end
            4'd5:  begin arch_word.fn = FN_ADD; arch_word.cin = CIN_PASS; end
            4'd6:  begin arch_word.fn = FN_SUB; arch_word.cin = CIN_PASS; end
            4'd7:  begin arch_word.fn = FN_RSB; arch_word.cin = CIN_PASS; end
            4'd8:  begin arch_word.fn = FN_AND; arch_word.arith = 1'b0; arch_word.result_wr = 1'b0; end
            4'd9:  begin arch_word.fn = FN_EOR; arch_word.arith = 1'b0; arch_word.result_wr = 1'b0; end
            4'd10: begin arch_word.fn = FN_SUB; arch_word.cin = CIN_ONE;  arch_word.result_wr = 1'b0; end
            4'd11: begin arch_word.fn = FN_ADD; arch_word.cin = CIN_ZERO; arch_word.result_wr = 1'b0; end
            4'd12: begin arch_word.fn = FN_ORR; arch_word.arith = 1'b0; end
            4'd13: begin arch_word.fn = FN_MOV; arch_word.arith = 1'b0; end
            4'd14: begin arch_word.fn = FN_BIC; arch_word.arith = 1'b0; end
            default: begin arch_word.fn = FN_MVN; arch_word.arith = 1'b0; end
        endcase
    end

    // Fixed internal operations; opcode is not consulted.
    always_comb begin
        int_word.flag_upd  = 1'b0;
        int_word.result_wr = 1'b1;
        int_word.arith     = 1'b1;
        int_word.cin       = CIN_ZERO;
        int_word.fn        = FN_ADD;
        unique case (seq_cmd)
            3'd0: begin int_word.fn = FN_MOV; int_word.arith = 1'b0; end
            3'd1: begin int_word.fn = FN_ADD; int_word.cin = CIN_ZERO; end
            3'd2: begin int_word.fn = FN_ADD; int_word.cin = CIN_ONE;  end
            3'd3: begin int_word.fn = FN_RSB; int_word.cin = CIN_ZERO; end
            3'd4: begin int_word.fn = FN_SUB; int_word.cin = CIN_ONE;  end
            3'd5: begin int_word.fn = FN_RSB; int_word.cin = CIN_ONE;  end
            default: begin int_word.fn = FN_ADD; int_word.cin = CIN_PASS; end
        endcase
    end

    // Pick the opcode entry only for the architectural command.
    always_comb begin
        word = (seq_cmd == CMD_ARCH) ? arch_word : int_word;
    end
endmodule

// File: rtl/alu_ctrl_carry.sv
// Carry-in path: one-cycle delay of the status carry, then pass or force.
// Assumes status_carry is stable at the clock edge.
module alu_ctrl_carry
    import alu_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     status_carry,
    input  cin_sel_e cin_sel,
    output logic     alu_cin
);
    logic carry_q;

    // Hold the status carry for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= status_carry;
    end

    // Select delayed carry or a constant for ALU bit 0.
    always_comb begin
        unique case (cin_sel)
            CIN_PASS: alu_cin = carry_q;
            CIN_ONE:  alu_cin = 1'b1;
            default:  alu_cin = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_ctrl_op1_en.sv
// Operand-1 latch enable: decoder request, or a zero command on the previous edge.
// Assumes the latch samples at the rising edge ending the cycle.
module alu_ctrl_op1_en
    import alu_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] seq_cmd,
    input  logic             op1_load_req,
    output logic             op1_latch_en
);
    logic zero_seen_q;

    // Remember that all command bits were low at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) zero_seen_q <= 1'b0;
        else        zero_seen_q <= (seq_cmd == CMD_ZERO);
    end

    // Merge the two enable sources.
    always_comb begin
        op1_latch_en = op1_load_req | zero_seen_q;
    end
endmodule

// File: rtl/alu_ctrl_decoder.sv
// Top of the ALU control decoder: decode table, carry path, operand-1 enable.
// Assumes synchronous active-low reset; outputs are combinational from inputs and state.
module alu_ctrl_decoder
    import alu_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] seq_cmd,
    input  logic [OPC_W-1:0] opcode,
    input  logic             status_carry,
    input  logic             op1_load_req,
    output logic [FN_W-1:0]  alu_fn,
    output logic             alu_cin,
    output logic             flag_upd,
    output logic             arith_op,
    output logic             result_wr,
    output logic             op1_latch_en
);
    ctl_word_t word;

    alu_ctrl_table i_table (
        .seq_cmd (seq_cmd),
        .opcode  (opcode),
        .word    (word)
    );

    alu_ctrl_carry i_carry (
        .clk          (clk),
        .rst_n        (rst_n),
        .status_carry (status_carry),
        .cin_sel      (word.cin),
        .alu_cin      (alu_cin)
    );

    alu_ctrl_op1_en i_op1 (
        .clk          (clk),
        .rst_n        (rst_n),
        .seq_cmd      (seq_cmd),
        .op1_load_req (op1_load_req),
        .op1_latch_en (op1_latch_en)
    );

    // Fan the control word out to the ports.
    always_comb begin
        alu_fn    = word.fn;
        flag_upd  = word.flag_upd;
        arith_op  = word.arith;
        result_wr = word.result_wr;
    end
endmodule

// File: rtl/alu_ctrl_checker.sv
// Port-level properties of the ALU control decoder, bound to the top.
module alu_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] seq_cmd,
    input logic [3:0] opcode,
    input logic       status_carry,
    input logic       op1_load_req,
    input logic [3:0] alu_fn,
    input logic       alu_cin,
    input logic       flag_upd,
    input logic       arith_op,
    input logic       result_wr,
    input logic       op1_latch_en
);
    logic past_ok;

    // Mark cycles that have a valid previous cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_CARRY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && seq_cmd == 3'b111 && opcode == 4'd5) |-> (alu_cin == $past(status_carry))); // R2
    AST_FORCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cmd == 3'b111 && (opcode == 4'd2 || opcode == 4'd10)) |-> alu_cin); // R3
    AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cmd == 3'b111 && opcode == 4'd4) |-> !alu_cin); // R3
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cmd == 3'b111 && opcode[3:2] == 2'b10) |-> !result_wr); // R5
    AST_INTERNAL_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cmd != 3'b111) |-> (!flag_upd && result_wr)); // R6
    AST_LOGIC_NOT_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cmd == 3'b111 && (opcode[3:2] == 2'b11 || opcode == 4'd0 || opcode == 4'd1)) |-> !arith_op); // R7
    AST_INT_CARRY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cmd == 3'b010) |-> (alu_cin && alu_fn == 4'd4)); // R8
    AST_OP1_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(seq_cmd) == 3'b000) |-> op1_latch_en); // R9
    AST_OP1_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        op1_load_req |-> op1_latch_en); // R9
endmodule

bind alu_ctrl_decoder alu_ctrl_checker i_chk (.*);

// File: tb/test_alu_ctrl_decoder.sv
// Bench: behavioural reference compared on every clock.
module test_alu_ctrl_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] seq_cmd = 3'd0;
    logic [3:0] opcode = 4'd0;
    logic       status_carry = 1'b0;
    logic       op1_load_req = 1'b0;
    logic [3:0] alu_fn;
    logic       alu_cin, flag_upd, arith_op, result_wr, op1_latch_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    bit m_carry = 1'b0;
    bit m_zero  = 1'b0;

    always #4 clk = ~clk;

    alu_ctrl_decoder i_alu_ctrl_decoder (.*);

    // Model state follows the requirement text at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin m_carry <= 1'b0; m_zero <= 1'b0; end
        else begin m_carry <= status_carry; m_zero <= (seq_cmd == 3'd0); end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s cmd=%0d opc=%0d actual=%0d expected=%0d",
                     req, what, seq_cmd, opcode, act, exp);
        end
    endtask

    // Compare all outputs against the model; call between edges.
    task automatic compare();
        int efn; int ecin; int ewr; int eupd; int ear; int cmode; // cmode 0 zero,1 one,2 pass
        int o;
        o = opcode;
        if (seq_cmd == 3'd7) begin
            eupd = 1;
            ewr  = (o >= 8 && o <= 11) ? 0 : 1;
            ear  = ((o >= 2 && o <= 7) || o == 10 || o == 11) ? 1 : 0;
            case (o)
                0, 8:  efn = 0;
                1, 9:  efn = 1;
                2, 6, 10: efn = 2;
                3, 7:  efn = 3;
                4, 5, 11: efn = 4;
                12: efn = 5;
                13: efn = 6;
                14: efn = 7;
                default: efn = 8;
            endcase
            if (o >= 5 && o <= 7) cmode = 2;
            else if (o == 2 || o == 3 || o == 10) cmode = 1;
            else cmode = 0;
        end else begin
            eupd = 0; ewr = 1;
            case (seq_cmd)
                3'd0: begin efn = 6; cmode = 0; ear = 0; end
                3'd1: begin efn = 4; cmode = 0; ear = 1; end
                3'd2: begin efn = 4; cmode = 1; ear = 1; end
                3'd3: begin efn = 3; cmode = 0; ear = 1; end
                3'd4: begin efn = 2; cmode = 1; ear = 1; end
                3'd5: begin efn = 3; cmode = 1; ear = 1; end
                default: begin efn = 4; cmode = 2; ear = 1; end
            endcase
        end
        ecin = (cmode == 2) ? int'(m_carry) : cmode;
        chk((seq_cmd == 3'd7) ? "R4" : "R8", "alu_fn", alu_fn, efn);
        chk((cmode == 2) ? "R2" : "R3", "alu_cin", alu_cin, ecin);
        chk("R5", "result_wr", result_wr, ewr);
        chk("R6", "flag_upd", flag_upd, eupd);
        chk("R7", "arith_op", arith_op, ear);
        chk("R9", "op1_latch_en", op1_latch_en, int'(op1_load_req | m_zero));
    endtask

    task automatic step(input logic [2:0] c, input logic [3:0] op, input logic cy, input logic rq);
        @(negedge clk);
        seq_cmd = c; opcode = op; status_carry = cy; op1_load_req = rq;
        #2 compare();
    endtask

    initial begin
        // Reset with carry high and zero command held: state must still clear.
        seq_cmd = 3'd0; status_carry = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        seq_cmd = 3'd7; opcode = 4'd5; op1_load_req = 1'b0;
        #2;
        chk("R1", "reset alu_cin", alu_cin, 0);
        chk("R1", "reset op1_latch_en", op1_latch_en, 0);
        // Full sweep of every command and opcode, twice, varying carry.
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < 8; c++) begin
                for (int op = 0; op < 16; op++) begin
                    step(3'(c), 4'(op), 1'((op + c + pass) % 3 == 1), 1'((op ^ c) == 5));
                end
            end
        end
        // Coincidence: zero command then add-with-carry with carry flipped (R2 with R9).
        for (int k = 0; k < 8; k++) begin
            step(3'd0, 4'(k), 1'(k & 1), 1'b0);
            step(3'd7, 4'd5, 1'(~k & 1), 1'b0);
            step(3'd7, 4'd6, 1'(k & 1), 1'b0);
        end
        // Opcode ignored for internal commands (R8): hold command, sweep opcode.
        for (int op = 0; op < 16; op++) step(3'd3, 4'(op), 1'b1, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule